// File: doc/BRIEF.md
# Convolution-Scheduled Multiply-Accumulate Engine

This block forms the coefficients of a schoolbook long multiplication, or of a plain discrete convolution, from two operands held as arrays of `DATA_W`-bit words. After a start pulse it walks its own index schedule. For every coefficient index k it visits each word pair (i, j) with i + j = k, reads word i of operand A and word j of operand B through two synchronous read ports with a latency of one cycle, multiplies the pair and sums the products into a coefficient that is three words wide.

One coefficient leaves per completed k, in increasing k, on a valid/ready output. A downstream merge stage can then fold the coefficients into a final product in lockstep. In convolution mode the coefficients are the result itself, and a tag on the output tells the receiver so. Both operand lengths are given at run time with the start pulse. The extra word of accumulator width holds the carries of the summation. The block therefore never overflows as long as `LEN_W` does not exceed `DATA_W`.

Top module: `conv_mac_engine`

## Requirements
- R1: Each emitted coefficient with index k equals the exact sum of A[i]·B[j] over all in-range i + j = k. It is carried at 3·`DATA_W` bits with no wraparound when `LEN_W` ≤ `DATA_W`.
- R2: Every read of A uses an address below the latched A length, and every read of B uses an address below the latched B length. Read data is taken on the cycle after the read strobe.
- R3: For lengths na, nb ≥ 1, exactly na+nb−1 coefficients are emitted. `coef_idx_o` runs 0, 1, …, na+nb−2, in order and without gaps.
- R4: While `coef_valid_o` is high and `coef_ready_i` is low, `coef_valid_o`, `coef_o` and `coef_idx_o` hold their values.
- R5: `start_i` is accepted only while `busy_o` is low. An accepted start latches both lengths and the mode. A start raised while busy has no effect on the run in progress.
- R6: `coef_result_o` reflects the latched mode: 1 means convolution mode, where the coefficient is a final result. 0 means multiply mode, where the coefficient is meant for a merge stage.
- R7: `done_o` rises on the clock edge that completes the handshake of the last coefficient. It stays high until the next accepted start clears it.
- R8: An accepted start with either length equal to zero issues no reads and emits no coefficient. It sets `done_o` on the accepting edge, and `busy_o` stays low.
- R9: After reset, `coef_valid_o`, `busy_o`, `done_o`, `a_rd_o` and `b_rd_o` are low.
- R10: `busy_o` is high from the edge that accepts a start with nonzero lengths until the edge that completes the handshake of the last coefficient. No read is issued while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| len_a_i | input | LEN_W | Word count of operand A |
| len_b_i | input | LEN_W | Word count of operand B |
| conv_mode_i | input | 1 | 1 = convolution, 0 = multiply |
| a_rd_o | output | 1 | Read strobe, operand A |
| a_addr_o | output | LEN_W | Word index i into A |
| a_data_i | input | DATA_W | A word, one cycle after strobe |
| b_rd_o | output | 1 | Read strobe, operand B |
| b_addr_o | output | LEN_W | Word index j into B |
| b_data_i | input | DATA_W | B word, one cycle after strobe |
| coef_valid_o | output | 1 | Coefficient available |
| coef_ready_i | input | 1 | Receiver accepts coefficient |
| coef_o | output | 3*DATA_W | Coefficient value |
| coef_idx_o | output | LEN_W+1 | Coefficient index k |
| coef_result_o | output | 1 | Coefficient is a final result (convolution mode) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last coefficient delivered |

## Verification
The bench sweeps every length pair up to six words against four operand patterns and three ready patterns.

- All-ones words push each sum to its largest value. This separates a full-width accumulator from one that drops the carry word.
- A single nonzero word at opposite ends of the two operands exposes an off-by-one in the index bounds, because exactly one coefficient may be nonzero.
- Distinct per-index values catch swapped or mirrored addresses.
- Alternating zero and full words catch a term that is skipped or counted twice.

Stalling and pulsed ready patterns test whether results survive backpressure. Two more runs cover the extremes: a maximum-length run and zero-length starts. A start pulsed in the middle of a run tells a correct idle-only latch from one that reloads.

// File: rtl/conv_mac_pkg.sv
package conv_mac_pkg;
  typedef enum logic {
    MODE_MULT = 1'b0,
    MODE_CONV = 1'b1
  } coef_mode_e;

  function automatic int unsigned acc_width(int unsigned dw);
    return 3 * dw;
  endfunction
endpackage

// File: rtl/conv_idx_sched.sv
module conv_idx_sched #(
  parameter int unsigned LEN_W = 16,
  localparam int unsigned K_W = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_a_i,
  input  logic [LEN_W-1:0] len_b_i,
  input  logic             last_ok_i,
  output logic             issue_o,
  output logic [LEN_W-1:0] i_o,
  output logic [LEN_W-1:0] j_o,
  output logic [K_W-1:0]   k_o,
  output logic             first_o,
  output logic             last_o,
  output logic             final_o,
  output logic             active_o,
  output logic [LEN_W-1:0] na_o,
  output logic [LEN_W-1:0] nb_o
);
  logic [LEN_W-1:0] na_q, nb_q, i_q;
  logic [K_W-1:0]   k_q, k_inc, na_x, nb_x, i_x;
  logic [K_W-1:0]   lo_k, hi_k, lo_next, k_last;
  logic             active_q, last_term, final_term;

  assign na_x  = K_W'(na_q);
  assign nb_x  = K_W'(nb_q);
  assign i_x   = K_W'(i_q);
  assign k_inc = k_q + K_W'(1);

  // i window for the current k and the next one
  assign lo_k    = (k_inc > nb_x) ? k_inc - nb_x : '0;
  assign lo_next = (k_inc + K_W'(1) > nb_x) ? k_inc + K_W'(1) - nb_x : '0;
  assign hi_k    = (k_q < na_x - K_W'(1)) ? k_q : na_x - K_W'(1);
  assign k_last  = na_x + nb_x - K_W'(2);

  assign last_term  = (i_x == hi_k);
  assign final_term = last_term && (k_q == k_last);

  // a closing term only goes out when the output slot can take it
  assign issue_o  = active_q && (!last_term || last_ok_i);
  assign i_o      = i_q;
  assign j_o      = LEN_W'(k_q - i_x);
  assign k_o      = k_q;
  assign first_o  = (i_x == lo_k);
  assign last_o   = last_term;
  assign final_o  = final_term;
  assign active_o = active_q;
  assign na_o     = na_q;
  assign nb_o     = nb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      na_q     <= '0;
      nb_q     <= '0;
      i_q      <= '0;
      k_q      <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      na_q     <= len_a_i;
      nb_q     <= len_b_i;
      i_q      <= '0;
      k_q      <= '0;
      active_q <= (len_a_i != '0) && (len_b_i != '0);
    end else if (issue_o) begin
      if (last_term) begin
        if (final_term) begin
          active_q <= 1'b0;
        end else begin
          k_q <= k_inc;
          i_q <= LEN_W'(lo_next);
        end
      end else begin
        i_q <= i_q + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/conv_mac_acc.sv
module conv_mac_acc #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned K_W    = 17,
  localparam int unsigned PROD_W = 2 * DATA_W,
  localparam int unsigned ACC_W  = conv_mac_pkg::acc_width(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic              final_i,
  input  logic [K_W-1:0]    idx_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              out_ready_i,
  output logic              slot_ok_o,
  output logic              out_valid_o,
  output logic [ACC_W-1:0]  out_data_o,
  output logic [K_W-1:0]    out_idx_o,
  output logic              out_final_o
);
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  acc_q, sum;
  logic              out_valid_q, out_final_q;
  logic [ACC_W-1:0]  out_data_q;
  logic [K_W-1:0]    out_idx_q;

  assign prod = PROD_W'(a_i) * PROD_W'(b_i);
  assign sum  = first_i ? ACC_W'(prod) : acc_q + ACC_W'(prod);

  // free next cycle, and no closing term already in flight
  assign slot_ok_o = (!out_valid_q || out_ready_i) && !(valid_i && last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (valid_i) begin
      acc_q <= sum;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_idx_q   <= '0;
      out_final_q <= 1'b0;
    end else if (valid_i && last_i) begin
      out_valid_q <= 1'b1;
      out_data_q  <= sum;
      out_idx_q   <= idx_i;
      out_final_q <= final_i;
    end else if (out_ready_i) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
  assign out_idx_o   = out_idx_q;
  assign out_final_o = out_final_q;
endmodule

// File: rtl/conv_mac_engine.sv
module conv_mac_engine
  import conv_mac_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 16,
  localparam int unsigned K_W   = LEN_W + 1,
  localparam int unsigned ACC_W = acc_width(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_a_i,
  input  logic [LEN_W-1:0]  len_b_i,
  input  logic              conv_mode_i,
  output logic              a_rd_o,
  output logic [LEN_W-1:0]  a_addr_o,
  input  logic [DATA_W-1:0] a_data_i,
  output logic              b_rd_o,
  output logic [LEN_W-1:0]  b_addr_o,
  input  logic [DATA_W-1:0] b_data_i,
  output logic              coef_valid_o,
  input  logic              coef_ready_i,
  output logic [ACC_W-1:0]  coef_o,
  output logic [K_W-1:0]    coef_idx_o,
  output logic              coef_result_o,
  output logic              busy_o,
  output logic              done_o
);
  logic             start_acc, zero_len;
  logic             issue, t_first, t_last, t_final, active, slot_ok;
  logic [LEN_W-1:0] t_i, t_j, len_a_q, len_b_q;
  logic [K_W-1:0]   t_k;
  logic             s1_valid_q, s1_first_q, s1_last_q, s1_final_q;
  logic [K_W-1:0]   s1_k_q;
  logic             out_final, done_q;
  coef_mode_e       mode_q;

  assign start_acc = start_i && !busy_o;
  assign zero_len  = (len_a_i == '0) || (len_b_i == '0);

  conv_idx_sched #(.LEN_W(LEN_W)) i_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_acc),
    .len_a_i   (len_a_i),
    .len_b_i   (len_b_i),
    .last_ok_i (slot_ok),
    .issue_o   (issue),
    .i_o       (t_i),
    .j_o       (t_j),
    .k_o       (t_k),
    .first_o   (t_first),
    .last_o    (t_last),
    .final_o   (t_final),
    .active_o  (active),
    .na_o      (len_a_q),
    .nb_o      (len_b_q)
  );

  assign a_rd_o   = issue;
  assign a_addr_o = t_i;
  assign b_rd_o   = issue;
  assign b_addr_o = t_j;

  // term tags wait one cycle alongside the memory read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_first_q <= 1'b0;
      s1_last_q  <= 1'b0;
      s1_final_q <= 1'b0;
      s1_k_q     <= '0;
    end else begin
      s1_valid_q <= issue;
      s1_first_q <= t_first;
      s1_last_q  <= t_last;
      s1_final_q <= t_final;
      s1_k_q     <= t_k;
    end
  end

  conv_mac_acc #(.DATA_W(DATA_W), .K_W(K_W)) i_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (s1_valid_q),
    .first_i     (s1_first_q),
    .last_i      (s1_last_q),
    .final_i     (s1_final_q),
    .idx_i       (s1_k_q),
    .a_i         (a_data_i),
    .b_i         (b_data_i),
    .out_ready_i (coef_ready_i),
    .slot_ok_o   (slot_ok),
    .out_valid_o (coef_valid_o),
    .out_data_o  (coef_o),
    .out_idx_o   (coef_idx_o),
    .out_final_o (out_final)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_MULT;
      done_q <= 1'b0;
    end else if (start_acc) begin
      mode_q <= conv_mode_i ? MODE_CONV : MODE_MULT;
      done_q <= zero_len;
    end else if (coef_valid_o && coef_ready_i && out_final) begin
      done_q <= 1'b1;
    end
  end

  assign coef_result_o = (mode_q == MODE_CONV);
  assign busy_o        = active || s1_valid_q || coef_valid_o;
  assign done_o        = done_q;
endmodule

// File: rtl/conv_mac_chk.sv
module conv_mac_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 16,
  localparam int unsigned K_W   = LEN_W + 1,
  localparam int unsigned ACC_W = 3 * DATA_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             a_rd_o,
  input logic [LEN_W-1:0] a_addr_o,
  input logic             b_rd_o,
  input logic [LEN_W-1:0] b_addr_o,
  input logic [LEN_W-1:0] len_a_q,
  input logic [LEN_W-1:0] len_b_q,
  input logic             coef_valid_o,
  input logic             coef_ready_i,
  input logic [ACC_W-1:0] coef_o,
  input logic [K_W-1:0]   coef_idx_o,
  input logic             busy_o,
  input logic             done_o
);
  logic           seen_q;
  logic [K_W-1:0] prev_idx_q;

  AST_A_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_rd_o |-> a_addr_o < len_a_q);  // R2
  AST_B_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_rd_o |-> b_addr_o < len_b_q);  // R2
  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_valid_o && !coef_ready_i |=> coef_valid_o && $stable(coef_o) && $stable(coef_idx_o));  // R4
  AST_LEN_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(len_a_q) && $stable(len_b_q));  // R5
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !coef_valid_o);  // R7
  AST_IDLE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !a_rd_o && !b_rd_o);  // R10

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= 1'b0;
      prev_idx_q <= '0;
    end else begin
      if (coef_valid_o && coef_ready_i) begin
        AST_IDX_STEP: assert (seen_q ? coef_idx_o == prev_idx_q + K_W'(1) : coef_idx_o == '0);  // R3
        seen_q     <= 1'b1;
        prev_idx_q <= coef_idx_o;
      end
      if (start_i && !busy_o) seen_q <= 1'b0;
    end
  end
endmodule

bind conv_mac_engine conv_mac_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .a_rd_o       (a_rd_o),
  .a_addr_o     (a_addr_o),
  .b_rd_o       (b_rd_o),
  .b_addr_o     (b_addr_o),
  .len_a_q      (len_a_q),
  .len_b_q      (len_b_q),
  .coef_valid_o (coef_valid_o),
  .coef_ready_i (coef_ready_i),
  .coef_o       (coef_o),
  .coef_idx_o   (coef_idx_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/test_conv_mac_engine.sv
module test_conv_mac_engine;
  localparam int DW = 8;
  localparam int LW = 4;
  localparam int KW = LW + 1;
  localparam int AW = 3 * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] len_a = '0, len_b = '0;
  logic          mode = 1'b0;
  logic          a_rd, b_rd;
  logic [LW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic          c_valid, c_result, busy, done;
  logic          c_ready = 1'b0;
  logic [AW-1:0] c_data;
  logic [KW-1:0] c_idx;

  logic [DW-1:0] mem_a [16];
  logic [DW-1:0] mem_b [16];
  longint        exp_c [32];
  int            n_chk = 0;
  int            n_bad = 0;

  always #4 clk = ~clk;

  conv_mac_engine #(.DATA_W(DW), .LEN_W(LW)) i_conv_mac_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_a_i(len_a), .len_b_i(len_b),
    .conv_mode_i(mode), .a_rd_o(a_rd), .a_addr_o(a_addr), .a_data_i(a_data),
    .b_rd_o(b_rd), .b_addr_o(b_addr), .b_data_i(b_data), .coef_valid_o(c_valid),
    .coef_ready_i(c_ready), .coef_o(c_data), .coef_idx_o(c_idx),
    .coef_result_o(c_result), .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    if (a_rd) a_data <= mem_a[a_addr];
    if (b_rd) b_data <= mem_b[b_addr];
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [DW-1:0] word_of(int pat, int side, int idx, int len);
    case (pat)
      0: return 8'hFF;
      1: return DW'((idx * 37 + side * 91 + 11) % 256);
      2: return (side == 0) ? ((idx == 0) ? 8'hC3 : 8'h00) : ((idx == len - 1) ? 8'h5A : 8'h00);
      default: return ((idx + side) % 2 == 0) ? 8'hFF : 8'h00;
    endcase
  endfunction

  function automatic bit ready_of(int bp, int cyc);
    case (bp)
      0: return 1'b1;
      1: return cyc[0];
      default: return (cyc % 4) == 3;
    endcase
  endfunction

  task automatic run(input int na, input int nb, input bit md, input int pat, input int bp, input bit poke);
    int     total, got, cyc;
    bit     held;
    longint h_data, h_idx;
    for (int x = 0; x < 16; x++) begin
      mem_a[x] = (x < na) ? word_of(pat, 0, x, na) : 8'h00;
      mem_b[x] = (x < nb) ? word_of(pat, 1, x, nb) : 8'h00;
    end
    for (int k = 0; k < 32; k++) exp_c[k] = 0;
    for (int i = 0; i < na; i++)
      for (int j = 0; j < nb; j++)
        exp_c[i + j] += longint'(mem_a[i]) * longint'(mem_b[j]);
    total = na + nb - 1;
    @(negedge clk);
    len_a = LW'(na); len_b = LW'(nb); mode = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R10 busy after start", busy, 1);
    got = 0; cyc = 0; held = 1'b0; h_data = 0; h_idx = 0;
    while (got < total && cyc < 3000) begin
      if (poke) begin
        start = (cyc == 3);
        len_a = (cyc == 3) ? LW'(2) : LW'(na);
        len_b = (cyc == 3) ? LW'(2) : LW'(nb);
      end
      c_ready = ready_of(bp, cyc);
      if (held) begin
        check(c_valid && longint'(c_data) == h_data && longint'(c_idx) == h_idx,
              "R4 hold under stall", longint'(c_data), h_data);
      end
      held = 1'b0;
      if (c_valid) begin
        if (c_ready) begin
          check(longint'(c_idx) == longint'(got), "R3 index order", longint'(c_idx), got);
          check(longint'(c_data) == exp_c[got], "R1 coefficient value", longint'(c_data), exp_c[got]);
          check(c_result == md, "R6 mode tag", c_result, md);
          got++;
        end else begin
          held = 1'b1; h_data = longint'(c_data); h_idx = longint'(c_idx);
        end
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    c_ready = 1'b0;
    check(got == total, "R3 coefficient count", got, total);
    if (poke) check(got == total, "R5 start ignored while busy", got, total);
    check(done == 1'b1 && busy == 1'b0 && c_valid == 1'b0, "R7 done after last", done, 1);
    @(negedge clk);
    check(done == 1'b1, "R7 done held", done, 1);
  endtask

  initial begin
    #1;
    check(c_valid == 0 && busy == 0 && done == 0 && a_rd == 0 && b_rd == 0, "R9 reset state", c_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(c_valid == 0 && busy == 0 && done == 0 && a_rd == 0, "R9 after release", busy, 0);

    // zero lengths
    for (int z = 0; z < 2; z++) begin
      @(negedge clk);
      len_a = (z == 0) ? LW'(0) : LW'(3);
      len_b = (z == 0) ? LW'(3) : LW'(0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done == 1 && busy == 0 && c_valid == 0, "R8 zero length done", done, 1);
      for (int w = 0; w < 3; w++) begin
        check(a_rd == 0 && b_rd == 0 && c_valid == 0, "R8 no reads", a_rd, 0);
        @(negedge clk);
      end
    end

    for (int na = 1; na <= 6; na++)
      for (int nb = 1; nb <= 6; nb++)
        for (int pat = 0; pat < 4; pat++)
          for (int bp = 0; bp < 3; bp++)
            run(na, nb, bit'((na + nb + pat) % 2), pat, bp, 1'b0);

    // start pulses while busy
    run(5, 4, 1'b0, 1, 2, 1'b1);
    run(3, 6, 1'b1, 3, 0, 1'b1);
    // longest operands, largest words: carry word in use
    run(15, 15, 1'b0, 0, 1, 1'b0);
    run(15, 7, 1'b1, 1, 0, 1'b0);
    // done cleared by next start
    @(negedge clk);
    len_a = 4'd2; len_b = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 0 && busy == 1, "R7 done cleared by start", done, 0);
    c_ready = 1'b1;
    repeat (20) @(negedge clk);
    check(done == 1, "R7 done after short run", done, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule